// File: doc/BRIEF.md
# Shaped-Carrier Three-Phase Gate Modulator

This block drives the six gate signals of a two-level, three-phase voltage-source inverter. All three phase references keep a fixed unit amplitude in every operating range. Each leg compares its own doubled reference with one shared shaped carrier, q = g·k − z. Here k is a symmetric triangle that spans −1 to +1, g is a gain picked from a small table by the modulation-index code, and z is the zero-sequence value that the upstream sector logic selects. Since only the carrier is reshaped, one multiplier, one subtractor and three comparators cover both the linear range and overmodulation.

All signed data uses Q2.14 format, where 1.0 is 16384. The modulation-index code is the table address, with m = code / 2^LUT_AW. The gain is unsigned with G_FRAC fraction bits. A new gain is taken only when the carrier sits at its +1 extreme, so changing the index partway through a period never splits a period between two gains. The gate outputs are registered. Reference generation, dead time and fault handling are left to neighbouring blocks.

Top module: `shaped_carrier_modulator`

## Requirements
- R1: The carrier counter c runs 0,1,…,H,H−1,…,1,0,1,… with H = 2^HALF_LOG2. It advances one step per clock edge and is 0 at the first edge after reset. The carrier value is k = 16384 − c·32768/H, so each edge changes k by exactly ±32768/H and k stays within ±16384.
- R2: The gain table entry for index i (N = 2^LUT_AW entries, G_FRAC = 10) depends on the region. When (2i+1)·1000 < 907·2N it is floor((3294198·N·1024 + d/2)/d), with d = (2i+1)·2^20, which is π·N/(2i+1) rounded. Otherwise it is floor(1773·(2N−2i−1)·1000/(2N·93)), a line that falls from the 0.907 boundary to zero at m = 1. Every entry is clamped to 2^G_W−1.
- R3: The scaled carrier is floor(k·g / 2^G_FRAC), saturated to the range −32768…32767 and never wrapped.
- R4: The upper gate of phase p is 1 after an edge exactly when 2·ref_p ≥ sat(k·g) − zseq. The value uses the references, zseq and carrier state present at that edge. With zseq set to the median of three balanced references, this gives min-max zero-sequence modulation.
- R5: Outside reset, after the first edge, each lower gate is the complement of the upper gate of the same leg.
- R6: The gain register loads the table entry addressed by m_code_i only at an edge where c = 0. At any other edge a change of m_code_i has no effect on the gates. The gain resets to 0.
- R7: While rst_ni is low, all six gate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | 16 | Phase A reference, signed Q2.14 |
| ref_b_i | input | 16 | Phase B reference, signed Q2.14 |
| ref_c_i | input | 16 | Phase C reference, signed Q2.14 |
| zseq_i | input | 16 | Zero-sequence value from the sector logic, signed Q2.14 |
| m_code_i | input | LUT_AW | Modulation-index code, m = code / 2^LUT_AW |
| gate_hi_o | output | 3 | Upper gates, bit 0 = A, bit 1 = B, bit 2 = C |
| gate_lo_o | output | 3 | Lower gates, same bit order |

## Verification
A gate decision becomes visible one clock edge after the references, zseq and carrier state it depends on are sampled. A gain loaded at an edge with c = 0 first affects the decision made at the following edge. The bench drives its inputs at the falling edge and forms its expectation from its own carrier counter and latched gain. It then updates that model across the rising edge and compares the outputs at the next falling edge, so every comparison is made exactly one edge after its stimulus. Reset values are checked while reset is held, before any rising edge after release.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int unsigned REF_W  = 16;
  localparam int unsigned FRAC_W = 14;
  localparam int unsigned G_W    = 18;
  localparam int unsigned G_FRAC = 10;

  localparam logic signed [REF_W-1:0] UNIT = REF_W'(1 << FRAC_W);

  localparam longint PI_Q20   = 3294198;
  localparam longint G_EDGE   = 1773;   // pi/(2*0.907) in G_FRAC=10
  localparam longint OM_MILLI = 907;

  // gain table entry: pi/(2m) below the overmodulation edge, linear to zero above
  function automatic logic [G_W-1:0] gain_entry(int idx, int n);
    longint d;
    longint v;
    if (longint'(2*idx+1) * 1000 < OM_MILLI * 2 * n) begin
      d = longint'(2*idx+1) * 1048576;
      v = (PI_Q20 * n * (longint'(1) << G_FRAC) + d / 2) / d;
    end else begin
      v = (G_EDGE * longint'(2*n - 2*idx - 1) * 1000) / (longint'(2*n) * 93);
    end
    if (v > (longint'(1) << G_W) - 1) v = (longint'(1) << G_W) - 1;
    return G_W'(v);
  endfunction
endpackage

// File: rtl/scm_carrier.sv
module scm_carrier
  import scm_pkg::*;
#(
  parameter int unsigned HALF_LOG2 = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  output logic signed [REF_W-1:0] k_o,
  output logic                    peak_o
);
  localparam int unsigned CNT_W   = HALF_LOG2 + 1;
  localparam int unsigned HALF    = 1 << HALF_LOG2;
  localparam int unsigned STEP_SH = FRAC_W + 1 - HALF_LOG2;
  localparam int          STEP    = 1 << STEP_SH;

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic [REF_W-1:0] off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(HALF - 1)) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
    end
  end

  // 16-bit wrap is exact: 16384 - 32768 = -16384
  assign off    = REF_W'(cnt_q) << STEP_SH;
  assign k_o    = UNIT - signed'(off);
  assign peak_o = (cnt_q == '0);

  p_carrier_bounds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_o >= -UNIT) && (k_o <= UNIT));

  p_carrier_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((int'(k_o) - int'($past(k_o)) == STEP) ||
                       (int'(k_o) - int'($past(k_o)) == -STEP)));
endmodule

// File: rtl/scm_gain_lut.sv
module scm_gain_lut
  import scm_pkg::*;
#(
  parameter int unsigned LUT_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LUT_AW-1:0] idx_i,
  input  logic              load_i,
  output logic [G_W-1:0]    g_o
);
  localparam int unsigned LUT_N = 1 << LUT_AW;

  logic [G_W-1:0] tab [LUT_N];
  logic [G_W-1:0] g_q;

  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_row
    localparam logic [G_W-1:0] ENTRY = gain_entry(gi, LUT_N);
    assign tab[gi] = ENTRY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     g_q <= '0;
    else if (load_i) g_q <= tab[idx_i];
  end

  assign g_o = g_q;

  p_gain_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(load_i)) |-> (g_o == $past(g_o)));
endmodule

// File: rtl/scm_leg.sv
module scm_leg
  import scm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic signed [REF_W:0]   q_i,
  output logic                  hi_o,
  output logic                  lo_o
);
  logic signed [REF_W:0] ref2;
  logic                  on;

  assign ref2 = {ref_i, 1'b0};
  assign on   = (ref2 >= q_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= on;
      lo_o <= ~on;
    end
  end

  p_complement_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (lo_o == ~hi_o));
endmodule

// File: rtl/shaped_carrier_modulator.sv
module shaped_carrier_modulator
  import scm_pkg::*;
#(
  parameter int unsigned HALF_LOG2 = 6,
  parameter int unsigned LUT_AW    = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [REF_W-1:0] ref_a_i,
  input  logic signed [REF_W-1:0] ref_b_i,
  input  logic signed [REF_W-1:0] ref_c_i,
  input  logic signed [REF_W-1:0] zseq_i,
  input  logic [LUT_AW-1:0]       m_code_i,
  output logic [2:0]              gate_hi_o,
  output logic [2:0]              gate_lo_o
);
  localparam int unsigned PROD_W = REF_W + G_W + 1;
  localparam logic signed [PROD_W-1:0] P_MAX = PROD_W'((1 << (REF_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] P_MIN = -P_MAX - 1;

  logic signed [REF_W-1:0]  k;
  logic                     peak;
  logic [G_W-1:0]           g;
  logic signed [PROD_W-1:0] prod_full;
  logic signed [PROD_W-1:0] prod_sh;
  logic signed [REF_W-1:0]  prod_sat;
  logic signed [REF_W:0]    q;
  logic signed [REF_W-1:0]  ref_arr [3];

  scm_carrier #(.HALF_LOG2(HALF_LOG2)) carrier_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .k_o   (k),
    .peak_o(peak)
  );

  scm_gain_lut #(.LUT_AW(LUT_AW)) gain_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idx_i (m_code_i),
    .load_i(peak),
    .g_o   (g)
  );

  // single multiply shared by all legs
  assign prod_full = k * $signed({1'b0, g});
  assign prod_sh   = prod_full >>> G_FRAC;

  always_comb begin
    if (prod_sh > P_MAX)      prod_sat = P_MAX[REF_W-1:0];
    else if (prod_sh < P_MIN) prod_sat = P_MIN[REF_W-1:0];
    else                      prod_sat = prod_sh[REF_W-1:0];
  end

  assign q = {prod_sat[REF_W-1], prod_sat} - {zseq_i[REF_W-1], zseq_i};

  assign ref_arr[0] = ref_a_i;
  assign ref_arr[1] = ref_b_i;
  assign ref_arr[2] = ref_c_i;

  for (genvar li = 0; li < 3; li++) begin : g_leg
    scm_leg leg_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ref_i (ref_arr[li]),
      .q_i   (q),
      .hi_o  (gate_hi_o[li]),
      .lo_o  (gate_lo_o[li])
    );
  end

  p_reset_low_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_hi_o == 3'b000) && (gate_lo_o == 3'b000));
endmodule

// File: tb/shaped_carrier_modulator_tb_top.sv
module shaped_carrier_modulator_tb_top;
  localparam int HALF_LOG2 = 6;
  localparam int LUT_AW    = 6;
  localparam int H         = 1 << HALF_LOG2;
  localparam int N         = 1 << LUT_AW;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic signed [15:0] ra = '0, rb = '0, rc = '0, zs = '0;
  logic [LUT_AW-1:0] mc = '0;
  logic [2:0]        ghi, glo;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  int     b_cnt;
  bit     b_up;
  longint b_g;

  always #10 clk = ~clk;

  shaped_carrier_modulator #(.HALF_LOG2(HALF_LOG2), .LUT_AW(LUT_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc), .zseq_i(zs),
    .m_code_i(mc), .gate_hi_o(ghi), .gate_lo_o(glo)
  );

  function automatic longint exp_gain(int i);
    longint d;
    longint v;
    if (longint'(2*i+1) * 1000 < longint'(907) * 2 * N) begin
      d = longint'(2*i+1) * 1048576;
      v = (longint'(3294198) * N * 1024 + d / 2) / d;
    end else begin
      v = (longint'(1773) * (2*N - 2*i - 1) * 1000) / (longint'(2*N) * 93);
    end
    if (v > (longint'(1) << 18) - 1) v = (longint'(1) << 18) - 1;
    return v;
  endfunction

  function automatic int median3(int a, int b, int c);
    if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
    if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
    return c;
  endfunction

  function automatic logic [2:0] exp_hi(int cnt, longint g);
    longint k, p, q;
    logic [2:0] r;
    k = 16384 - longint'(cnt) * (32768 / H);
    p = (k * g) >>> 10;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    q = p - longint'(zs);
    r[0] = (2 * longint'(ra)) >= q;
    r[1] = (2 * longint'(rb)) >= q;
    r[2] = (2 * longint'(rc)) >= q;
    return r;
  endfunction

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_balanced();
    int a, b, c;
    a = int'($urandom_range(16384)) - 8192;
    b = int'($urandom_range(16384)) - 8192;
    c = -(a + b);
    ra = 16'(a); rb = 16'(b); rc = 16'(c);
    zs = 16'(median3(a, b, c));
  endtask

  // one clock: expectation from model, edge, model update, compare at falling edge
  task automatic step(string tag);
    logic [2:0] e;
    e = exp_hi(b_cnt, b_g);
    @(posedge clk);
    if (b_cnt == 0) b_g = exp_gain(int'(mc));
    if (b_up) begin
      b_cnt++;
      if (b_cnt == H) b_up = 1'b0;
    end else begin
      b_cnt--;
      if (b_cnt == 0) b_up = 1'b1;
    end
    @(negedge clk);
    check(tag, {3'b000, ghi}, {3'b000, e});
    check("R5", {3'b000, glo}, {3'b000, ~ghi});
  endtask

  initial begin
    void'($urandom(32'd4242));
    b_cnt = 0; b_up = 1'b1; b_g = 0;

    // R7: outputs low during reset, with busy inputs
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      set_balanced();
      mc = LUT_AW'($urandom);
      check("R7", {ghi, glo}, 6'b000000);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    check("R7", {ghi, glo}, 6'b000000);

    // R1: zero references, gain at index 0, gate follows carrier sign
    ra = '0; rb = '0; rc = '0; zs = '0; mc = '0;
    for (int i = 0; i < 2*H; i++) step("R1");

    // R4: undermodulation, balanced references, median zero sequence
    for (int i = 0; i < 6*H; i++) begin
      set_balanced();
      mc = LUT_AW'($urandom_range(57));
      step("R4");
    end

    // R2: index over the full range including overmodulation entries
    for (int i = 0; i < 8*H; i++) begin
      set_balanced();
      if (i % (2*H) == 0) mc = LUT_AW'($urandom);
      step("R2");
    end
    for (int j = N - 6; j < N; j++) begin
      mc = LUT_AW'(j);
      for (int i = 0; i < 2*H; i++) begin
        set_balanced();
        step("R2");
      end
    end

    // R3: largest gain, saturating product, extreme references
    mc = '0;
    for (int i = 0; i < 4*H; i++) begin
      case (i % 4)
        0: begin ra = 16'sd16384;  rb = -16'sd16384; rc = 16'sd0;     zs = 16'sd16384;  end
        1: begin ra = -16'sd16384; rb = 16'sd16383;  rc = 16'sd1;     zs = -16'sd16384; end
        2: begin ra = 16'sd16383;  rb = 16'sd0;      rc = -16'sd16383; zs = 16'sd0;     end
        default: set_balanced();
      endcase
      step("R3");
    end

    // R6: index toggles every cycle, only the value at c = 0 counts
    for (int i = 0; i < 6*H; i++) begin
      set_balanced();
      mc = (i % 2 == 0) ? LUT_AW'(0) : LUT_AW'(N - 1);
      if (i % 7 == 3) mc = LUT_AW'($urandom);
      step("R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule